// File: doc/BRIEF.md
# In-Phase Sub-Cycle Edge Phase Detector

This block measures how far a shifted square wave trails or leads a reference square wave that is meant to run in phase with it. Each system clock cycle it receives one word of eight consecutive samples per signal, taken by a deserializer in front of it. Bit 0 of each word is the earliest sample. It finds the edges of both waves to one eighth of a clock cycle and pairs each reference edge with the matching shifted edge. The result is a signed offset in clock cycles. The offset is positive when the shifted wave is late.

When the two levels disagree, the block decides which wave moved first. It takes as leader the wave that has left the level both signals last shared. A measurement ends when both signals agree again at the new level. Each new edge offset is averaged with the one before it, so rising-edge and falling-edge errors cancel. The average appears on a fixed-point output together with a one-cycle strobe, once per completed edge pair. The output therefore updates twice per signal period.

Each input changes level at most once within one word. The signals in use run far slower than the clock.

Top module: `pd_inphase_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `avg_valid` is 0 and `avg_offset` is 0. Both signals are taken to be at level 0 from reset.
- R2: An edge is placed at the index of the first sample in the word, scanning from bit 0 (earliest) to bit 7, that differs from the signal's previous level. Edge time is 8 × cycle + index, in eighths of a cycle.
- R3: A single edge offset equals the shifted edge time minus the reference edge time, in eighths of a cycle. When both signals change in the same word from a shared level, the offset is the shifted index minus the reference index. Equal indices give 0.
- R4: When the levels disagree, the signal that left the last shared level is the leader. The offset is positive if the reference leads and negative if the shifted signal leads. No strobe is issued until the other signal follows.
- R5: `avg_offset` is signed with 4 fraction bits (10.4). Its integer value equals the new offset plus the previous emitted offset, both counted in eighths. The previous offset is 0 after reset.
- R6: `avg_valid` is high for the cycle after the word that completes an edge pair. In every other cycle it is low and `avg_offset` holds its value.
- R7: If the leader returns to the shared level before the other signal moves, the measurement is dropped. No strobe is issued and the previous offset stays unchanged.
- R8: Offset magnitudes above 4095 eighths (511.875 cycles) saturate to +4095 or −4095.
- R9: In a word where both signals change while a measurement is open, order decides. If the follower's index is lower than the leader's return index, the pair is emitted and a new measurement opens at the leader's index with the same leader. Otherwise the pair is dropped and a new measurement opens at the follower's index with the follower as leader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_word | input | 8 | Reference samples for one cycle, bit 0 earliest |
| sft_word | input | 8 | Shifted-signal samples for one cycle, bit 0 earliest |
| avg_offset | output | 14 | Averaged signed offset, 10.4 fixed point in clock cycles |
| avg_valid | output | 1 | One-cycle strobe for each completed edge pair |

## Verification
The bench uses the default eight samples per word and ten integer bits. The integer range therefore ends near 512 cycles, and holding a measurement open for 510 to 700 idle words reaches both the last exact value and the clamp on each sign. With eight indices per word, every test can put the two edges at either end of a word, at equal indices, or split across words. Same-word ordering is covered both while a measurement is open and while none is open.

// File: rtl/pd_pkg.sv
package pd_pkg;
    typedef enum logic {
        LEAD_REF = 1'b0,
        LEAD_SFT = 1'b1
    } lead_e;

    localparam int unsigned PD_SPW_DEFAULT = 8;
    localparam int unsigned PD_INT_DEFAULT = 10;
endpackage

// File: rtl/pd_edge_locate.sv
module pd_edge_locate #(
    parameter int unsigned SPW   = 8,
    parameter int unsigned POS_W = $clog2(SPW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPW-1:0]   word,
    output logic             hit,
    output logic [POS_W-1:0] pos
);
    typedef struct packed {
        logic lvl;
    } loc_st_t;

    loc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = word[SPW-1];
        hit      = (word[SPW-1] != st_q.lvl);
        pos      = '0;
        // lowest index that has left the previous level wins
        for (int i = SPW - 1; i >= 0; i--) begin
            if (word[i] != st_q.lvl) begin
                pos = POS_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pd_pair_track.sv
module pd_pair_track
    import pd_pkg::*;
#(
    parameter int unsigned INT_BITS = 10,
    parameter int unsigned POS_W    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             r_hit,
    input  logic [POS_W-1:0]                 r_pos,
    input  logic                             s_hit,
    input  logic [POS_W-1:0]                 s_pos,
    output logic                             off_vld,
    output logic signed [INT_BITS+POS_W-1:0] off
);
    localparam int unsigned OFF_W    = INT_BITS + POS_W;
    localparam int unsigned ELAP_W   = INT_BITS + 1;
    localparam int unsigned MAG_W    = ELAP_W + POS_W + 1;
    localparam int unsigned MAG_MAX  = (2 ** (OFF_W - 1)) - 1;
    localparam int unsigned ELAP_MAX = 2 ** INT_BITS;

    typedef struct packed {
        logic              pend;
        lead_e             lead;
        logic [ELAP_W-1:0] elap;
        logic [POS_W-1:0]  spos;
    } trk_st_t;

    trk_st_t st_d, st_q;

    logic             lead_hit, lag_hit;
    logic [POS_W-1:0] pos_lead, pos_lag;
    logic [MAG_W-1:0] mag_w;
    logic [OFF_W-1:0] mag_s;
    logic             neg;

    always_comb begin
        st_d    = st_q;
        off_vld = 1'b0;
        mag_w   = '0;
        neg     = 1'b0;

        lead_hit = (st_q.lead == LEAD_REF) ? r_hit : s_hit;
        lag_hit  = (st_q.lead == LEAD_REF) ? s_hit : r_hit;
        pos_lead = (st_q.lead == LEAD_REF) ? r_pos : s_pos;
        pos_lag  = (st_q.lead == LEAD_REF) ? s_pos : r_pos;

        if (!st_q.pend) begin
            if (r_hit && s_hit) begin
                // both left the shared level inside one word
                off_vld = 1'b1;
                if (s_pos >= r_pos) begin
                    mag_w = MAG_W'(s_pos - r_pos);
                end else begin
                    mag_w = MAG_W'(r_pos - s_pos);
                    neg   = 1'b1;
                end
            end else if (r_hit) begin
                st_d.pend = 1'b1;
                st_d.lead = LEAD_REF;
                st_d.spos = r_pos;
                st_d.elap = ELAP_W'(1);
            end else if (s_hit) begin
                st_d.pend = 1'b1;
                st_d.lead = LEAD_SFT;
                st_d.spos = s_pos;
                st_d.elap = ELAP_W'(1);
            end
        end else begin
            mag_w = (MAG_W'(st_q.elap) << POS_W) + MAG_W'(pos_lag) - MAG_W'(st_q.spos);
            neg   = (st_q.lead == LEAD_SFT);
            if (lag_hit && (!lead_hit || (pos_lag < pos_lead))) begin
                // follower caught up: pair complete
                off_vld = 1'b1;
                if (lead_hit) begin
                    st_d.spos = pos_lead;
                    st_d.elap = ELAP_W'(1);
                end else begin
                    st_d.pend = 1'b0;
                end
            end else if (lead_hit) begin
                // leader went back first: drop this pair
                if (lag_hit) begin
                    st_d.lead = (st_q.lead == LEAD_REF) ? LEAD_SFT : LEAD_REF;
                    st_d.spos = pos_lag;
                    st_d.elap = ELAP_W'(1);
                end else begin
                    st_d.pend = 1'b0;
                end
            end else if (st_q.elap != ELAP_W'(ELAP_MAX)) begin
                st_d.elap = st_q.elap + ELAP_W'(1);
            end
        end

        mag_s = (mag_w > MAG_W'(MAG_MAX)) ? OFF_W'(MAG_MAX) : mag_w[OFF_W-1:0];
        off   = neg ? -$signed(mag_s) : $signed(mag_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pd_avg.sv
module pd_avg #(
    parameter int unsigned OFF_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic signed [OFF_W-1:0] in_off,
    output logic signed [OFF_W:0]   avg,
    output logic                    avg_vld
);
    localparam int unsigned OUT_W = OFF_W + 1;

    typedef struct packed {
        logic signed [OFF_W-1:0] prev;
        logic signed [OUT_W-1:0] sum;
        logic                    vld;
    } avg_st_t;

    avg_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            // sum of two 10.3 values read as 10.4 is their mean
            st_d.sum  = OUT_W'(in_off) + OUT_W'(st_q.prev);
            st_d.prev = in_off;
        end
        avg     = st_q.sum;
        avg_vld = st_q.vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pd_inphase_top.sv
module pd_inphase_top #(
    parameter int unsigned SPW      = pd_pkg::PD_SPW_DEFAULT,
    parameter int unsigned INT_BITS = pd_pkg::PD_INT_DEFAULT
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [SPW-1:0]                       ref_word,
    input  logic [SPW-1:0]                       sft_word,
    output logic signed [INT_BITS+$clog2(SPW):0] avg_offset,
    output logic                                 avg_valid
);
    localparam int unsigned POS_W = $clog2(SPW);
    localparam int unsigned OFF_W = INT_BITS + POS_W;
    localparam int unsigned NCH   = 2;

    logic [SPW-1:0]          words [NCH];
    logic                    hits  [NCH];
    logic [POS_W-1:0]        poss  [NCH];
    logic                    off_vld;
    logic signed [OFF_W-1:0] off;

    assign words[0] = ref_word;
    assign words[1] = sft_word;

    for (genvar c = 0; c < NCH; c++) begin : g_loc
        pd_edge_locate #(
            .SPW   (SPW),
            .POS_W (POS_W)
        ) u_loc (
            .clk   (clk),
            .rst_n (rst_n),
            .word  (words[c]),
            .hit   (hits[c]),
            .pos   (poss[c])
        );
    end

    pd_pair_track #(
        .INT_BITS (INT_BITS),
        .POS_W    (POS_W)
    ) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .r_hit   (hits[0]),
        .r_pos   (poss[0]),
        .s_hit   (hits[1]),
        .s_pos   (poss[1]),
        .off_vld (off_vld),
        .off     (off)
    );

    pd_avg #(
        .OFF_W (OFF_W)
    ) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (off_vld),
        .in_off  (off),
        .avg     (avg_offset),
        .avg_vld (avg_valid)
    );
endmodule

// File: rtl/pd_inphase_chk.sv
module pd_inphase_chk #(
    parameter int unsigned SPW   = 8,
    parameter int unsigned OUT_W = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [SPW-1:0]          ref_word,
    input logic [SPW-1:0]          sft_word,
    input logic signed [OUT_W-1:0] avg_offset,
    input logic                    avg_valid
);
    localparam int AV_LIM = (2 ** (OUT_W - 1)) - 2;

    logic ref_last, sft_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_last <= 1'b0;
            sft_last <= 1'b0;
        end else begin
            ref_last <= ref_word[SPW-1];
            sft_last <= sft_word[SPW-1];
        end
    end

    // R1: reset clears the outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!avg_valid && (avg_offset == '0)));

    // R6: output holds between strobes
    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_valid |-> $stable(avg_offset));

    // R6: a word without edges on either input gives no strobe
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ref_word == {SPW{ref_last}}) && (sft_word == {SPW{sft_last}})) |=> !avg_valid);

    // R3: matching edges from a shared level always complete a pair
    assert_coincident_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ref_last == sft_last) && (ref_word == sft_word) && (ref_word[SPW-1] != ref_last))
        |=> avg_valid);

    // R8: saturated offsets keep the average inside its reachable range
    assert_avg_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_offset >= -AV_LIM) && (avg_offset <= AV_LIM));
endmodule

bind pd_inphase_top pd_inphase_chk #(
    .SPW   (SPW),
    .OUT_W (INT_BITS + $clog2(SPW) + 1)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_word   (ref_word),
    .sft_word   (sft_word),
    .avg_offset (avg_offset),
    .avg_valid  (avg_valid)
);

// File: tb/sim_pd_inphase_top.sv
module sim_pd_inphase_top;
    localparam int SPW = 8;
    localparam int WD_CYCLES = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SPW-1:0]    ref_word = '0;
    logic [SPW-1:0]    sft_word = '0;
    logic signed [13:0] avg_offset;
    logic              avg_valid;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  rl = 1'b0;
    bit  sl = 1'b0;
    int  prev_off = 0;
    int  last_avg = 0;

    always #4 clk = ~clk;

    pd_inphase_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_word   (ref_word),
        .sft_word   (sft_word),
        .avg_offset (avg_offset),
        .avg_valid  (avg_valid)
    );

    function automatic logic [SPW-1:0] mk(input bit lvl, input int p);
        logic [SPW-1:0] w;
        for (int i = 0; i < SPW; i++) begin
            w[i] = (p >= 0 && i >= p) ? ~lvl : lvl;
        end
        return w;
    endfunction

    task automatic cmp(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // p < 0 means no edge in this word
    task automatic step(input int rp, input int sp);
        @(negedge clk);
        ref_word = mk(rl, rp);
        sft_word = mk(sl, sp);
        if (rp >= 0) rl = ~rl;
        if (sp >= 0) sl = ~sl;
        @(posedge clk);
        #2;
    endtask

    task automatic expect_emit(input string req, input int off);
        cmp({req, " strobe"}, int'(avg_valid), 1);
        cmp({req, " average"}, int'(avg_offset), off + prev_off);
        last_avg = off + prev_off;
        prev_off = off;
    endtask

    task automatic expect_none(input string req);
        cmp({req, " no strobe"}, int'(avg_valid), 0);
        cmp({req, " held"}, int'(avg_offset), last_avg);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp("R1 valid after reset", int'(avg_valid), 0);
        cmp("R1 avg after reset", int'(avg_offset), 0);
        step(-1, -1);
        expect_none("R1 idle");
    endtask

    task automatic t_positions;
        step(2, 5);
        expect_emit("R2 R3 same word", 3);
        step(7, 0);
        expect_emit("R2 R3 word ends", -7);
        step(-1, -1);
        expect_none("R6 after strobe");
    endtask

    task automatic t_leads;
        step(6, -1);
        expect_none("R4 ref leading open");
        step(-1, 1);
        expect_emit("R4 ref leads", 3);
        step(-1, 4);
        expect_none("R4 sft leading open");
        step(-1, -1);
        expect_none("R4 waiting");
        step(0, -1);
        expect_emit("R4 sft leads", -12);
    endtask

    task automatic t_discard;
        step(2, -1);
        expect_none("R7 leader out");
        step(6, -1);
        expect_none("R7 leader back");
        step(1, 1);
        expect_emit("R7 R5 prev kept", 0);
    endtask

    task automatic t_pending_both;
        step(3, -1);
        expect_none("R9 open");
        step(5, 1);
        expect_emit("R9 follower first", 6);
        step(-1, 5);
        expect_emit("R9 reopened pair", 8);
        step(-1, 2);
        expect_none("R9 sft open");
        step(4, 4);
        expect_none("R9 tie drops");
        step(-1, 6);
        expect_emit("R9 leader swapped", 10);
    endtask

    task automatic t_saturate;
        step(0, -1);
        repeat (510) step(-1, -1);
        expect_none("R6 long wait");
        step(-1, 7);
        expect_emit("R8 largest exact", 4095);
        step(0, -1);
        repeat (511) step(-1, -1);
        step(-1, 0);
        expect_emit("R8 clamp positive", 4095);
        step(-1, 0);
        repeat (700) step(-1, -1);
        step(0, -1);
        expect_emit("R8 clamp negative", -4095);
        step(-1, -1);
        expect_none("R6 after clamp");
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_positions();
        t_leads();
        t_discard();
        t_pending_both();
        t_saturate();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end
endmodule